// File: doc/BRIEF.md
# E1 Sa Bit Inserter

This block sits in the transmit path of an E1 line and overwrites the national spare bits (Sa4 to Sa8) of timeslot 0. It does this only in the frames that do not carry the frame alignment signal. The serial bit stream enters one bit per clock on `data_in` and leaves on `data_out` one clock later. Two sync inputs mark the frame structure. `frame_sync` is high on the first bit of every frame. `mf_sync` is high together with `frame_sync` on the first bit of frame 0 of each 16-frame multiframe. Frames are numbered 0 to 15 from that point, and the odd-numbered frames are the non-alignment frames that carry Sa bits.

There are four source settings on `src_sel`:
- **Fixed word**: a five-bit word is applied to every eligible frame.
- **Multiframe table**: eight values per Sa position are taken from a table. The table is captured at each multiframe boundary, so an update takes effect as a whole.
- **Serial feed**: a request/data pair lets an upstream HDLC or transparent-data controller supply one bit for each enabled position.
- **None**: nothing is overwritten.

A five-bit mask picks which Sa positions are overwritten. Positions outside the mask carry the incoming data.

Top module: `e1_sa_inserter`

## Requirements
- R1: Insertion happens only at bit indices 3 to 7 of a frame (index 0 is the first bit transmitted; index 3+j is Sa(4+j), j = 0..4) in odd-numbered frames. Frame 0 is the frame whose first bit has `frame_sync` and `mf_sync` both high, and frames count up by one on each `frame_sync` modulo 16.
- R2: Every bit that is not inserted appears on `data_out` exactly one clock after it is presented on `data_in`.
- R3: Sa position j is overwritten only when `sa_en[j]` is 1. Otherwise the incoming bit passes unchanged.
- R4: With `src_sel` = 0, an enabled position j takes the value `sa_word[j]`.
- R5: With `src_sel` = 1, an enabled position j in odd frame f takes bit `8*j + f/2` of the captured table.
- R6: With `src_sel` = 2, `hdlc_req` is high in the same cycle as the incoming bit of each enabled Sa position of an eligible frame, and low in every other cycle. That cycle's `hdlc_bit` is the inserted value.
- R7: `mf_bits` is captured only in a cycle where `frame_sync` and `mf_sync` are both high. A change at any other time has no effect on output until the next such cycle.
- R8: After reset, and until the first cycle with both syncs high, no bit is inserted and `hdlc_req` stays low.
- R9: With `src_sel` = 3, no bit is inserted and `hdlc_req` stays low.
- R10: While reset is held, `data_out` and `hdlc_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sync | input | 1 | High on the first bit of each frame |
| mf_sync | input | 1 | High with frame_sync on the first bit of frame 0 |
| data_in | input | 1 | Incoming serial bit |
| src_sel | input | 2 | 0 fixed word, 1 multiframe table, 2 serial feed, 3 none |
| sa_en | input | 5 | Bit j enables overwriting of Sa(4+j) |
| sa_word | input | 5 | Fixed-word values, bit j for Sa(4+j) |
| mf_bits | input | 40 | Table: bit 8*j+k is Sa(4+j) in the k-th non-alignment frame |
| hdlc_bit | input | 1 | Serial-feed bit, consumed when hdlc_req is high |
| hdlc_req | output | 1 | Serial feed request for the current bit |
| data_out | output | 1 | Outgoing serial bit, one clock latency |

## Verification
- **Bit position counter**: if it drifted, Sa values would land on neighbouring bits. Those bits carry known random data, so the error shows at the port within the first eligible frame, at most two frames later.
- **Frame counter and alignment flag**: a wrong frame counter or alignment flag would make insertions appear in alignment frames, or vanish from odd frames, within one frame time.
- **Captured table**: a table loaded at the wrong moment shows up as the old or new pattern in the wrong multiframe. The bench changes the table in the middle of a multiframe to expose this.
- **Serial request**: an incorrect request shows up in the very cycle it occurs, as a mismatch on `hdlc_req`.

// File: rtl/sa_ins_pkg.sv
`timescale 1ns/1ps
package sa_ins_pkg;
  localparam int unsigned SA_COUNT     = 5;
  localparam int unsigned SA_FIRST_BIT = 3;

  typedef enum logic [1:0] {
    SRC_WORD   = 2'd0,
    SRC_MFRAME = 2'd1,
    SRC_SERIAL = 2'd2,
    SRC_NONE   = 2'd3
  } sa_src_e;

  // true when a bit index falls on one of the spare-bit positions
  function automatic logic in_sa_window(input int unsigned pos,
                                        input int unsigned first,
                                        input int unsigned cnt);
    return (pos >= first) && (pos < first + cnt);
  endfunction

  // odd frame number -> rank among non-alignment frames
  function automatic int unsigned nfas_rank(input int unsigned frame);
    return frame >> 1;
  endfunction
endpackage

// File: rtl/sa_frame_tracker.sv
`timescale 1ns/1ps
module sa_frame_tracker
  import sa_ins_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 256,
  parameter int unsigned FRAMES_PER_MF  = 16,
  parameter int unsigned NUM_SA         = SA_COUNT,
  parameter int unsigned FIRST_SA_BIT   = SA_FIRST_BIT,
  localparam int unsigned BW = $clog2(BITS_PER_FRAME),
  localparam int unsigned FW = $clog2(FRAMES_PER_MF),
  localparam int unsigned KW = FW - 1,
  localparam int unsigned JW = $clog2(NUM_SA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  input  logic          mf_sync,
  output logic          sa_slot,
  output logic [JW-1:0] sa_idx,
  output logic [KW-1:0] nfas_idx,
  output logic          mf_start
);
  logic [BW-1:0] bit_q, cur_bit;
  logic [FW-1:0] frame_q, cur_frame;
  logic          aligned_q;

  always_comb begin
    mf_start = frame_sync & mf_sync;
    if (frame_sync || bit_q == BW'(BITS_PER_FRAME - 1)) cur_bit = '0;
    else                                                cur_bit = bit_q + 1'b1;
    if (mf_start)                                       cur_frame = '0;
    else if (frame_sync)
      cur_frame = (frame_q == FW'(FRAMES_PER_MF - 1)) ? '0 : frame_q + 1'b1;
    else                                                cur_frame = frame_q;
    sa_slot  = aligned_q & cur_frame[0]
             & in_sa_window(int'(cur_bit), FIRST_SA_BIT, NUM_SA);
    sa_idx   = JW'(cur_bit - BW'(FIRST_SA_BIT));
    nfas_idx = KW'(nfas_rank(int'(cur_frame)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      frame_q   <= '0;
      aligned_q <= 1'b0;
    end else begin
      bit_q   <= cur_bit;
      frame_q <= cur_frame;
      if (mf_start) aligned_q <= 1'b1;
    end
  end

  // R8
  aligned_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aligned_q |=> aligned_q);
  // R1
  sa_slot_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sa_slot) |-> (sa_idx == '0));
endmodule

// File: rtl/sa_mf_store.sv
`timescale 1ns/1ps
module sa_mf_store
  import sa_ins_pkg::*;
#(
  parameter int unsigned NUM_SA      = SA_COUNT,
  parameter int unsigned NFAS_PER_MF = 8,
  localparam int unsigned JW = $clog2(NUM_SA),
  localparam int unsigned KW = $clog2(NFAS_PER_MF),
  localparam int unsigned TW = NUM_SA * NFAS_PER_MF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] table_in,
  input  logic [JW-1:0] sa_idx,
  input  logic [KW-1:0] nfas_idx,
  output logic          bit_out
);
  logic [NFAS_PER_MF-1:0] lane_q [NUM_SA];
  logic [TW-1:0]          flat_q;

  for (genvar j = 0; j < NUM_SA; j++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q[j] <= '0;
      else if (load) lane_q[j] <= table_in[j*NFAS_PER_MF +: NFAS_PER_MF];
    end
    assign flat_q[j*NFAS_PER_MF +: NFAS_PER_MF] = lane_q[j];
  end

  always_comb begin
    bit_out = 1'b0;
    for (int j = 0; j < NUM_SA; j++)
      if (sa_idx == JW'(j)) bit_out = lane_q[j][nfas_idx];
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(flat_q));
endmodule

// File: rtl/sa_bit_select.sv
`timescale 1ns/1ps
module sa_bit_select
  import sa_ins_pkg::*;
#(
  parameter int unsigned NUM_SA = SA_COUNT,
  localparam int unsigned JW = $clog2(NUM_SA)
) (
  input  sa_src_e           src,
  input  logic [NUM_SA-1:0] sa_en,
  input  logic [NUM_SA-1:0] sa_word,
  input  logic              sa_slot,
  input  logic [JW-1:0]     sa_idx,
  input  logic              mf_bit,
  input  logic              hdlc_bit,
  output logic              ins,
  output logic              ins_val,
  output logic              hdlc_req
);
  logic en_bit, word_bit;

  always_comb begin
    en_bit   = 1'b0;
    word_bit = 1'b0;
    for (int j = 0; j < NUM_SA; j++)
      if (sa_idx == JW'(j)) begin
        en_bit   = sa_en[j];
        word_bit = sa_word[j];
      end
    ins      = 1'b0;
    ins_val  = 1'b0;
    hdlc_req = 1'b0;
    if (sa_slot && en_bit) begin
      unique case (src)
        SRC_WORD:   begin ins = 1'b1; ins_val = word_bit; end
        SRC_MFRAME: begin ins = 1'b1; ins_val = mf_bit;   end
        SRC_SERIAL: begin ins = 1'b1; ins_val = hdlc_bit; hdlc_req = 1'b1; end
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/e1_sa_inserter.sv
`timescale 1ns/1ps
module e1_sa_inserter
  import sa_ins_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 256,
  parameter int unsigned FRAMES_PER_MF  = 16,
  parameter int unsigned NUM_SA         = SA_COUNT,
  localparam int unsigned NFAS = FRAMES_PER_MF / 2,
  localparam int unsigned JW   = $clog2(NUM_SA),
  localparam int unsigned KW   = $clog2(NFAS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_sync,
  input  logic                   mf_sync,
  input  logic                   data_in,
  input  logic [1:0]             src_sel,
  input  logic [NUM_SA-1:0]      sa_en,
  input  logic [NUM_SA-1:0]      sa_word,
  input  logic [NUM_SA*NFAS-1:0] mf_bits,
  input  logic                   hdlc_bit,
  output logic                   hdlc_req,
  output logic                   data_out
);
  logic          sa_slot, mf_start, mf_bit, ins, ins_val;
  logic [JW-1:0] sa_idx;
  logic [KW-1:0] nfas_idx;
  sa_src_e       src;

  assign src = sa_src_e'(src_sel);

  sa_frame_tracker #(
    .BITS_PER_FRAME(BITS_PER_FRAME), .FRAMES_PER_MF(FRAMES_PER_MF),
    .NUM_SA(NUM_SA), .FIRST_SA_BIT(SA_FIRST_BIT)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mf_sync(mf_sync),
    .sa_slot(sa_slot), .sa_idx(sa_idx), .nfas_idx(nfas_idx), .mf_start(mf_start)
  );

  sa_mf_store #(.NUM_SA(NUM_SA), .NFAS_PER_MF(NFAS)) u_store (
    .clk(clk), .rst_n(rst_n), .load(mf_start), .table_in(mf_bits),
    .sa_idx(sa_idx), .nfas_idx(nfas_idx), .bit_out(mf_bit)
  );

  sa_bit_select #(.NUM_SA(NUM_SA)) u_sel (
    .src(src), .sa_en(sa_en), .sa_word(sa_word), .sa_slot(sa_slot),
    .sa_idx(sa_idx), .mf_bit(mf_bit), .hdlc_bit(hdlc_bit),
    .ins(ins), .ins_val(ins_val), .hdlc_req(hdlc_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_out <= 1'b0;
    else        data_out <= ins ? ins_val : data_in;
  end

  // R2
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins |=> (data_out == $past(data_in)));
  // R6
  serial_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdlc_req |-> (src == SRC_SERIAL) && sa_slot);
  // R9
  none_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_NONE) |-> !ins && !hdlc_req);
endmodule

// File: tb/e1_sa_inserter_bench.sv
`timescale 1ns/1ps
module e1_sa_inserter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0, mf_sync = 1'b0, data_in = 1'b0, hdlc_bit = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [4:0]  sa_en = '0, sa_word = '0;
  logic [39:0] mf_bits = '0;
  logic        hdlc_req, data_out;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  e1_sa_inserter u_e1_sa_inserter (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mf_sync(mf_sync),
    .data_in(data_in), .src_sel(src_sel), .sa_en(sa_en), .sa_word(sa_word),
    .mf_bits(mf_bits), .hdlc_bit(hdlc_bit), .hdlc_req(hdlc_req), .data_out(data_out)
  );

  // behavioural reference state
  bit          m_aligned = 0;
  bit [39:0]   m_table = '0;
  bit          exp_out;
  string       exp_tag;
  bit          have_exp = 0;
  bit [15:0]   lfsr = 16'hACE1;
  int          cur_f = 14;

  task automatic chk(input bit ok, input string tag, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic one_bit(input int b, input int f);
    bit req_e, val, slot;
    int j;
    @(negedge clk);
    if (have_exp) chk(data_out === exp_out, exp_tag, data_out, exp_out);
    frame_sync = (b == 0);
    mf_sync    = (b == 0) && (f == 0);
    data_in    = next_rand();
    hdlc_bit   = next_rand();
    #1;
    req_e   = 0;
    val     = data_in;
    exp_tag = "R1/R2";
    slot    = (f % 2 == 1) && (b >= 3) && (b <= 7);
    j       = b - 3;
    if (slot) begin
      if (!m_aligned) exp_tag = "R8";
      else if (!sa_en[j]) exp_tag = "R3";
      else begin
        case (src_sel)
          2'd0: begin exp_tag = "R4"; val = sa_word[j]; end
          2'd1: begin exp_tag = "R5/R7"; val = m_table[j*8 + f/2]; end
          2'd2: begin exp_tag = "R6"; val = hdlc_bit; req_e = 1; end
          default: exp_tag = "R9";
        endcase
      end
    end
    chk(hdlc_req === req_e, "R6 hdlc_req", hdlc_req, req_e);
    exp_out  = val;
    have_exp = 1;
    if (b == 0 && f == 0) begin
      m_aligned = 1;
      m_table   = mf_bits;
    end
  endtask

  task automatic run_frames(input int n);
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 256; b++) one_bit(b, cur_f);
      cur_f = (cur_f + 1) % 16;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs held low in reset
    chk(data_out === 1'b0, "R10 data_out", data_out, 1'b0);
    chk(hdlc_req === 1'b0, "R10 hdlc_req", hdlc_req, 1'b0);
    rst_n = 1'b1;
    // pre-alignment frames with insertion requested (R8)
    src_sel = 2'd2; sa_en = 5'b11111;
    run_frames(2);
    // fixed word, all enabled (R4)
    src_sel = 2'd0; sa_word = 5'b10110;
    run_frames(16);
    // fixed word, partial mask (R3)
    sa_en = 5'b01010; sa_word = 5'b11111;
    run_frames(16);
    // table, with mid-multiframe change (R5, R7)
    src_sel = 2'd1; sa_en = 5'b11111;
    mf_bits = 40'hA5_3C_F0_0F_96;
    run_frames(16);
    run_frames(5);
    mf_bits = 40'h12_34_56_78_9A;
    run_frames(11);
    run_frames(16);
    // serial feed, partial mask (R6)
    src_sel = 2'd2; sa_en = 5'b10011;
    run_frames(16);
    // no source (R9)
    src_sel = 2'd3; sa_en = 5'b11111;
    run_frames(16);
    // table with mask cleared (R3)
    src_sel = 2'd1; sa_en = 5'b00000;
    run_frames(16);
    @(negedge clk);
    chk(data_out === exp_out, exp_tag, data_out, exp_out);
    finish_up();
  end
endmodule